// File: doc/BRIEF.md
# Interrupt-Gated Page Walk Controller

This controller decides when a hardware page-table walk may begin for a miss in the instruction TLB or the data TLB. It also decides when a cache flush may begin, and it keeps interrupts and exceptions from breaking into an operation that has already started. A pending interrupt or exception in the decision cycle keeps a walk or flush from starting. This leaves the trap free to be taken cleanly. Once a walk or flush has begun, the `committed` output stays high, which tells the core not to take an interrupt against that operation. An interrupt that arrives after the TLB has been written waits for the next instruction.

A walk runs as a short sequence. First comes one stall cycle with the walker not yet selected. Then the walker is granted until a TLB write or a page fault comes back. A TLB write is followed by one closing cycle in which `committed` stays high. A fault drops everything in the next cycle. When both misses are present, the data side is walked first. The instruction side follows straight from the closing cycle. All outputs are registered.

Top module: `walk_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `stall`, `walker_grant`, `committed`, `flush_start` and `walk_is_instr` low and returns the controller to its ready state.
- R2: From ready, an accepted miss gives one cycle with `stall` high and `walker_grant` low. In the following cycles `walker_grant` and `stall` are both high until an outcome is seen.
- R3: A data TLB miss is a request only while `mem_req` is high. An instruction TLB miss is a request on its own.
- R4: If `irq_pending` or `exc_pending` is high in the ready-state decision cycle, neither a walk nor a flush starts, and all outputs stay low.
- R5: `committed` is high in every cycle from the first stall cycle of a walk or flush up to and including its final cycle. `walker_grant` never stands high without `committed`.
- R6: A `tlb_write` while granted leads to one closing cycle in which `committed` is high and `stall` and `walker_grant` are low. An interrupt pending in that cycle does not shorten or cancel it.
- R7: A `walk_fault` while granted leaves `committed`, `stall` and `walker_grant` low in the next cycle. If `walk_fault` and `tlb_write` come in the same cycle, the fault wins.
- R8: A walk request takes priority over `flush_req`. An accepted flush raises `flush_start` for exactly one cycle, and it holds `stall` and `committed` high until `flush_done`.
- R9: With both misses present, the data walk goes first (`walk_is_instr` = 0). If the instruction miss is still present and no interrupt or exception is pending in the closing cycle, the instruction walk's stall cycle (`walk_is_instr` = 1) comes directly after that closing cycle.
- R10: `tlb_write` and `walk_fault` have no effect while the walker is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| itlb_miss | input | 1 | Instruction TLB miss in fetch |
| dtlb_miss | input | 1 | Data TLB miss in memory stage |
| mem_req | input | 1 | A memory operation is present in memory stage |
| flush_req | input | 1 | Cache flush request |
| irq_pending | input | 1 | Interrupt pending |
| exc_pending | input | 1 | Exception pending |
| tlb_write | input | 1 | Walk finished with a TLB write |
| walk_fault | input | 1 | Walk finished with a page fault |
| flush_done | input | 1 | Flush finished |
| stall | output | 1 | Stall the core |
| walker_grant | output | 1 | Memory port handed to the walker |
| committed | output | 1 | Operation in progress; no interrupt may be taken against it |
| flush_start | output | 1 | One-cycle flush start pulse |
| walk_is_instr | output | 1 | Current walk serves the instruction side |

## Verification
Directed sequences cover several cases. A lone data miss with and without `mem_req` separates request qualification from the miss itself. A miss held while an interrupt is pending shows the start suppression. Both misses together test the data-first order and the chained instruction walk. A fault and a write in the same cycle show fault precedence. An interrupt raised during the closing cycle shows the deferral. A flush arriving alongside a miss tests walk priority over the flush. Outcome pulses sent outside a walk show that they are ignored. Seeded random traffic then mixes all inputs, so that walks, flushes and pending traps overlap in orders the directed cases do not reach.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int WG_STATE_W = 3;
  typedef enum logic [WG_STATE_W-1:0] {
    WG_READY = 3'd0,
    WG_PREP  = 3'd1,
    WG_WALK  = 3'd2,
    WG_DONE  = 3'd3,
    WG_FLUSH = 3'd4
  } wg_state_e;
endpackage

// File: rtl/wg_req_qual.sv
module wg_req_qual (
  input  logic itlb_miss,
  input  logic dtlb_miss,
  input  logic mem_req,
  input  logic flush_req,
  input  logic irq_pending,
  input  logic exc_pending,
  output logic ireq,
  output logic blocked,
  output logic go_walk,
  output logic go_flush,
  output logic pick_instr
);
  logic dreq;
  // data miss only counts with a live memory operation
  assign dreq       = dtlb_miss & mem_req;
  assign ireq       = itlb_miss;
  assign blocked    = irq_pending | exc_pending;
  assign go_walk    = (dreq | ireq) & ~blocked;
  assign go_flush   = flush_req & ~(dreq | ireq) & ~blocked;
  assign pick_instr = ~dreq;
endmodule

// File: rtl/wg_fsm.sv
module wg_fsm
  import wg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      go_walk,
  input  logic      go_flush,
  input  logic      pick_instr,
  input  logic      ireq,
  input  logic      blocked,
  input  logic      tlb_write,
  input  logic      walk_fault,
  input  logic      flush_done,
  output wg_state_e state_q,
  output wg_state_e state_d,
  output logic      side_d
);
  logic side_q;

  always_comb begin
    state_d = state_q;
    side_d  = side_q;
    case (state_q)
      WG_READY: begin
        if (go_walk) begin
          state_d = WG_PREP;
          side_d  = pick_instr;
        end else if (go_flush) begin
          state_d = WG_FLUSH;
        end
      end
      WG_PREP:  state_d = WG_WALK;
      WG_WALK: begin
        if (walk_fault)     state_d = WG_READY;
        else if (tlb_write) state_d = WG_DONE;
      end
      WG_DONE: begin
        if (!side_q && ireq && !blocked) begin
          state_d = WG_PREP;
          side_d  = 1'b1;
        end else begin
          state_d = WG_READY;
        end
      end
      WG_FLUSH: if (flush_done) state_d = WG_READY;
      default:  state_d = WG_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WG_READY;
      side_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      side_q  <= side_d;
    end
  end

  // R4: a pending trap in ready keeps the controller in ready
  a_r4_blocked_stays_ready: assert property (@(posedge clk) disable iff (rst)
    (state_q == WG_READY && blocked) |=> (state_q == WG_READY));
  // R10: outcome pulses do nothing outside the walk state
  a_r10_ack_ignored_in_prep: assert property (@(posedge clk) disable iff (rst)
    (state_q == WG_PREP) |=> (state_q == WG_WALK));
  // R7: a fault always returns to ready
  a_r7_fault_to_ready: assert property (@(posedge clk) disable iff (rst)
    (state_q == WG_WALK && walk_fault) |=> (state_q == WG_READY));
endmodule

// File: rtl/wg_outreg.sv
module wg_outreg
  import wg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wg_state_e state_q,
  input  wg_state_e state_d,
  input  logic      side_d,
  input  logic      tlb_write,
  input  logic      walk_fault,
  output logic      stall,
  output logic      walker_grant,
  output logic      committed,
  output logic      flush_start,
  output logic      walk_is_instr
);
  logic in_walk_d;
  assign in_walk_d = (state_d == WG_PREP) || (state_d == WG_WALK) || (state_d == WG_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stall         <= 1'b0;
      walker_grant  <= 1'b0;
      committed     <= 1'b0;
      flush_start   <= 1'b0;
      walk_is_instr <= 1'b0;
    end else begin
      stall         <= (state_d == WG_PREP) || (state_d == WG_WALK) || (state_d == WG_FLUSH);
      walker_grant  <= (state_d == WG_WALK);
      committed     <= (state_d != WG_READY);
      flush_start   <= (state_d == WG_FLUSH) && (state_q != WG_FLUSH);
      walk_is_instr <= in_walk_d && side_d;
    end
  end

  // R1: reset clears every output
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!stall && !walker_grant && !committed && !flush_start && !walk_is_instr));
  // R2: grant is preceded by a stall cycle without grant
  a_r2_stall_before_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(walker_grant) |-> ($past(stall) && !$past(walker_grant)));
  // R5: grant implies committed
  a_r5_grant_committed: assert property (@(posedge clk) disable iff (rst)
    walker_grant |-> committed);
  // R7: fault drops committed next cycle
  a_r7_fault_drops_commit: assert property (@(posedge clk) disable iff (rst)
    (walker_grant && walk_fault) |=> (!committed && !walker_grant));
  // R6: a write keeps committed through the closing cycle
  a_r6_write_holds_commit: assert property (@(posedge clk) disable iff (rst)
    (walker_grant && tlb_write && !walk_fault) |=> (committed && !walker_grant));
  // R8: flush start is a single-cycle pulse
  a_r8_flush_pulse: assert property (@(posedge clk) disable iff (rst)
    flush_start |=> !flush_start);
endmodule

// File: rtl/walk_gate_ctrl.sv
module walk_gate_ctrl
  import wg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic itlb_miss,
  input  logic dtlb_miss,
  input  logic mem_req,
  input  logic flush_req,
  input  logic irq_pending,
  input  logic exc_pending,
  input  logic tlb_write,
  input  logic walk_fault,
  input  logic flush_done,
  output logic stall,
  output logic walker_grant,
  output logic committed,
  output logic flush_start,
  output logic walk_is_instr
);
  logic      ireq, blocked, go_walk, go_flush, pick_instr, side_d;
  wg_state_e state_q, state_d;

  wg_req_qual u_qual (
    .itlb_miss(itlb_miss), .dtlb_miss(dtlb_miss), .mem_req(mem_req),
    .flush_req(flush_req), .irq_pending(irq_pending), .exc_pending(exc_pending),
    .ireq(ireq), .blocked(blocked), .go_walk(go_walk), .go_flush(go_flush),
    .pick_instr(pick_instr)
  );

  wg_fsm u_fsm (
    .clk(clk), .rst(rst), .go_walk(go_walk), .go_flush(go_flush),
    .pick_instr(pick_instr), .ireq(ireq), .blocked(blocked),
    .tlb_write(tlb_write), .walk_fault(walk_fault), .flush_done(flush_done),
    .state_q(state_q), .state_d(state_d), .side_d(side_d)
  );

  wg_outreg u_out (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d), .side_d(side_d),
    .tlb_write(tlb_write), .walk_fault(walk_fault),
    .stall(stall), .walker_grant(walker_grant), .committed(committed),
    .flush_start(flush_start), .walk_is_instr(walk_is_instr)
  );
endmodule

// File: tb/walk_gate_ctrl_test.sv
`timescale 1ns/1ps
module walk_gate_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic itlb_miss, dtlb_miss, mem_req, flush_req, irq_pending, exc_pending;
  logic tlb_write, walk_fault, flush_done;
  logic stall, walker_grant, committed, flush_start, walk_is_instr;

  int checks = 0;
  int errors = 0;

  // model: 0 ready, 1 prep, 2 walk, 3 done, 4 flush
  int  ms = 0;
  logic mside = 1'b0;

  always #10 clk = ~clk;

  walk_gate_ctrl uut (
    .clk(clk), .rst(rst), .itlb_miss(itlb_miss), .dtlb_miss(dtlb_miss),
    .mem_req(mem_req), .flush_req(flush_req), .irq_pending(irq_pending),
    .exc_pending(exc_pending), .tlb_write(tlb_write), .walk_fault(walk_fault),
    .flush_done(flush_done), .stall(stall), .walker_grant(walker_grant),
    .committed(committed), .flush_start(flush_start), .walk_is_instr(walk_is_instr)
  );

  function automatic logic [4:0] expect_out(input int st, input int pst, input logic sd);
    logic [4:0] v;
    v[4] = (st == 1) || (st == 2) || (st == 4);          // stall
    v[3] = (st == 2);                                    // grant
    v[2] = (st != 0);                                    // committed
    v[1] = (st == 4) && (pst != 4);                      // flush_start
    v[0] = sd && ((st == 1) || (st == 2) || (st == 3));  // walk_is_instr
    return v;
  endfunction

  task automatic idle_inputs();
    itlb_miss = 0; dtlb_miss = 0; mem_req = 0; flush_req = 0;
    irq_pending = 0; exc_pending = 0; tlb_write = 0; walk_fault = 0; flush_done = 0;
  endtask

  task automatic cyc(input string tag);
    logic dq, iq, blk;
    int prev;
    logic [4:0] exp_v, act_v;
    @(posedge clk);
    dq = dtlb_miss & mem_req; iq = itlb_miss; blk = irq_pending | exc_pending;
    prev = ms;
    if (rst) begin
      ms = 0; mside = 0;
    end else begin
      case (ms)
        0: if ((dq | iq) && !blk) begin ms = 1; mside = !dq; end
           else if (flush_req && !blk) ms = 4;
        1: ms = 2;
        2: if (walk_fault) ms = 0; else if (tlb_write) ms = 3;
        3: if (!mside && iq && !blk) begin ms = 1; mside = 1; end else ms = 0;
        4: if (flush_done) ms = 0;
        default: ms = 0;
      endcase
    end
    @(negedge clk);
    exp_v = rst ? 5'b0 : expect_out(ms, prev, mside);
    act_v = {stall, walker_grant, committed, flush_start, walk_is_instr};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {stall,grant,committed,flush_start,instr} actual %b expected %b at %0t",
               tag, act_v, exp_v, $time);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst = 0;
    cyc("R1");

    // R3: data miss without memory op ignored, then with it accepted
    dtlb_miss = 1; cyc("R3"); cyc("R3");
    mem_req = 1; cyc("R3");
    dtlb_miss = 0; mem_req = 0;
    cyc("R2"); cyc("R2");
    tlb_write = 1; cyc("R6"); tlb_write = 0;
    irq_pending = 1; cyc("R6"); irq_pending = 0;  // closing cycle unaffected
    cyc("R6");

    // R4: blocked starts
    itlb_miss = 1; irq_pending = 1; cyc("R4"); cyc("R4");
    irq_pending = 0; exc_pending = 1; flush_req = 1; cyc("R4");
    exc_pending = 0; itlb_miss = 0; cyc("R4"); // flush now starts
    flush_req = 0; cyc("R8"); cyc("R8");
    flush_done = 1; cyc("R8"); flush_done = 0; cyc("R8");

    // R8: miss beats flush
    itlb_miss = 1; flush_req = 1; cyc("R8");
    itlb_miss = 0; flush_req = 0; cyc("R8");
    // R7: fault and write together, fault wins
    walk_fault = 1; tlb_write = 1; cyc("R7");
    walk_fault = 0; tlb_write = 0; cyc("R7");

    // R10: outcome pulses outside a walk
    tlb_write = 1; walk_fault = 1; cyc("R10"); cyc("R10");
    tlb_write = 0; walk_fault = 0;
    itlb_miss = 1; cyc("R10");
    itlb_miss = 0; tlb_write = 1; walk_fault = 1; cyc("R10"); // prep cycle
    tlb_write = 0; walk_fault = 0; cyc("R10");
    walk_fault = 1; cyc("R7"); walk_fault = 0; cyc("R7");

    // R9: both misses, data first, instruction chained
    itlb_miss = 1; dtlb_miss = 1; mem_req = 1; cyc("R9");
    cyc("R9"); cyc("R9");
    dtlb_miss = 0; mem_req = 0; tlb_write = 1; cyc("R9");
    tlb_write = 0; cyc("R9");
    itlb_miss = 0; cyc("R9"); cyc("R9");
    tlb_write = 1; cyc("R9"); tlb_write = 0; cyc("R9"); cyc("R9");

    // R9 with interrupt in the closing cycle: instruction walk waits
    itlb_miss = 1; dtlb_miss = 1; mem_req = 1; cyc("R9"); cyc("R9");
    tlb_write = 1; cyc("R9"); tlb_write = 0; irq_pending = 1; cyc("R9");
    cyc("R4"); irq_pending = 0; cyc("R9");
    idle_inputs(); cyc("R9"); tlb_write = 1; cyc("R9"); tlb_write = 0; cyc("R9"); cyc("R9");

    // random traffic with fixed seed
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      itlb_miss   = ($urandom % 4) == 0;
      dtlb_miss   = ($urandom % 3) == 0;
      mem_req     = ($urandom % 2) == 0;
      flush_req   = ($urandom % 5) == 0;
      irq_pending = ($urandom % 4) == 0;
      exc_pending = ($urandom % 8) == 0;
      tlb_write   = ($urandom % 4) == 0;
      walk_fault  = ($urandom % 6) == 0;
      flush_done  = ($urandom % 3) == 0;
      rst         = ($urandom % 500) == 0;
      cyc(rst ? "R1" : "R2");
    end
    rst = 0; idle_inputs();
    cyc("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule